// File: doc/BRIEF.md
# Switch Register Access Bridge

This block lets a host processor reach the configuration registers of an Ethernet switch core through a small memory-mapped window on a 32-bit register bus. A switch register is named by an 8-bit page and an 8-bit register number. The value it holds is up to 64 bits wide. On the switch side the bridge drives a level request carrying page, register, direction and 64-bit write data. It waits for a one-cycle acknowledge, which comes with 64-bit read data.

The host first claims the switch-side bus. It sets a request bit in the control word and polls until the grant bit appears. It then loads the two write-data words if the access is a write. Next it writes one packed command word whose go bit starts the access. The go bit reads back as 1 while the access is in flight and drops by itself once the switch acknowledges. Read results are then picked up from two read-data words. An internal switch agent competes for the same bus. The arbiter never lets the two own it at once. A reset bit in the command word abandons an access that never completes.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset the grant is 0, `sw_req` and `agent_gnt` are 0, and the command, write-data and read-data words read 0. The control word reads only the init-done status in bit 6.
- R2: The control word is at offset 0x40. Bit 3 (access request) and bit 1 (interrupt enable) are written and read back. Bit 4 (grant) and bit 6 (`sw_init_done` input) ignore host writes. All other bits read 0.
- R3: When the request bit is set and the agent holds no grant, the grant bit reads 1 one cycle after the request bit first reads 1. Clearing the request bit makes the grant read 0 one cycle later.
- R4: `agent_gnt` is given only while the host neither requests nor holds the grant and no host access is pending. The host grant is withheld while the agent is granted. Both grants are never 1 together, and `agent_gnt` is never 1 while `sw_req` is 1.
- R5: The command word is at offset 0x2C, with page in bits 31:24, register in bits 23:16, write flag in bit 1 (1 = write) and go in bit 0. A command with go=1 written while granted and idle raises `sw_req` in the next cycle. The page, register and write flag go out on `sw_page`, `sw_reg` and `sw_write`, and these hold while `sw_req` is 1.
- R6: Command bit 0 reads 1 while the access is pending. It reads 0, and `sw_req` is 0, in the cycle after `sw_ack` is sampled high.
- R7: The write-data high word is at offset 0x30 and the low word at 0x34. `sw_wdata` equals the high word shifted left by 32, ORed with the low word.
- R8: When a read (write flag 0) is acknowledged, the word at offset 0x38 takes `sw_rdata[63:32]` and the word at 0x3C takes `sw_rdata[31:0]`. Both keep their value through write accesses until the next read completes.
- R9: A command written while the grant is not held is ignored. The command word stays unchanged with bit 0 at 0, and `sw_req` stays 0.
- R10: Writing the command word with bit 2 set abandons a pending access. Go and `sw_req` are 0 in the next cycle, the read-data words are unchanged, and a later `sw_ack` is ignored.
- R11: A command written while an access is pending is ignored. Page, register and direction of the pending access are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte offset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on `host_addr` |
| sw_init_done | input | 1 | Switch initialisation finished |
| agent_req | input | 1 | Internal agent bus request |
| agent_gnt | output | 1 | Internal agent bus grant |
| sw_req | output | 1 | Switch-side access request (level) |
| sw_page | output | 8 | Switch register page |
| sw_reg | output | 8 | Switch register number |
| sw_write | output | 1 | 1 = write access |
| sw_wdata | output | 64 | Switch write data |
| sw_ack | input | 1 | Switch-side access done (one cycle) |
| sw_rdata | input | 64 | Switch read data, valid with `sw_ack` |

## Verification
The bench goes after four corner cases, each of which a faulty design gets wrong in a visible way:
- A command issued without the grant. A bridge that skips the grant check would raise `sw_req` and corrupt switch state during agent ownership.
- A second command arriving during a pending access. Accepting it would change the page mid-access.
- An abort followed by a stray acknowledge. A bridge that keeps listening would overwrite the read-data words.
- Write completions following reads. A capture that ignores direction would smear write data into the read words.

Arbitration is driven in both orders, to catch a grant that overlaps the agent or fails to release.

// File: rtl/srab_pkg.sv
package srab_pkg;
  localparam logic [7:0] OFF_CMD = 8'h2C;
  localparam logic [7:0] OFF_WHI = 8'h30;
  localparam logic [7:0] OFF_WLO = 8'h34;
  localparam logic [7:0] OFF_RHI = 8'h38;
  localparam logic [7:0] OFF_RLO = 8'h3C;
  localparam logic [7:0] OFF_CTL = 8'h40;

  localparam int CMD_GO   = 0;
  localparam int CMD_WR   = 1;
  localparam int CMD_ABT  = 2;
  localparam int CMD_REGL = 16;
  localparam int CMD_PGL  = 24;

  localparam int CTL_IEN  = 1;
  localparam int CTL_REQ  = 3;
  localparam int CTL_GNT  = 4;
  localparam int CTL_INIT = 6;

  localparam int SEL_W = 8;

  typedef struct packed {
    logic [SEL_W-1:0] page;
    logic [SEL_W-1:0] regn;
    logic             wr;
  } srab_cmd_t;
endpackage

// File: rtl/srab_arbiter.sv
module srab_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic busy,
  input  logic agent_req,
  output logic host_gnt,
  output logic agent_gnt
);
  logic host_gnt_q, host_gnt_d;
  logic agent_gnt_q, agent_gnt_d;

  always_comb begin
    host_gnt_d  = host_req & (host_gnt_q | ~agent_gnt_q);
    agent_gnt_d = agent_req & (agent_gnt_q | (~host_req & ~host_gnt_q & ~busy));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_gnt_q  <= 1'b0;
      agent_gnt_q <= 1'b0;
    end else begin
      host_gnt_q  <= host_gnt_d;
      agent_gnt_q <= agent_gnt_d;
    end
  end

  assign host_gnt  = host_gnt_q;
  assign agent_gnt = agent_gnt_q;
endmodule

// File: rtl/srab_host_regs.sv
module srab_host_regs
  import srab_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              req,
  output logic              ien,
  output logic [HOST_W-1:0] wd_hi,
  output logic [HOST_W-1:0] wd_lo
);
  localparam int NWORD = 2;
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(OFF_CTL);

  logic              ctl_en;
  logic              req_d, ien_d;
  logic              req_q, ien_q;
  logic [HOST_W-1:0] word_q [NWORD];

  always_comb begin
    ctl_en = host_we && (host_addr == CTL_A);
    req_d  = host_wdata[CTL_REQ];
    ien_d  = host_wdata[CTL_IEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (ctl_en) begin
      req_q <= req_d;
      ien_q <= ien_d;
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'((w == 0) ? OFF_WHI : OFF_WLO);
    logic wen;
    always_comb wen = host_we && (host_addr == WA);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= '0;
      else if (wen) word_q[w] <= host_wdata;
    end
  end

  assign req   = req_q;
  assign ien   = ien_q;
  assign wd_hi = word_q[0];
  assign wd_lo = word_q[1];
endmodule

// File: rtl/srab_cmd_engine.sv
module srab_cmd_engine
  import srab_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_we,
  input  logic [HOST_W-1:0]   host_wdata,
  input  logic                host_gnt,
  input  logic                sw_ack,
  input  logic [2*HOST_W-1:0] sw_rdata,
  output logic                busy,
  output srab_cmd_t           cmd,
  output logic [HOST_W-1:0]   rd_hi,
  output logic [HOST_W-1:0]   rd_lo
);
  localparam int SW_W = 2 * HOST_W;
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(OFF_CMD);

  logic      cmd_hit, abort, start, done, cap;
  logic      busy_d, busy_q;
  srab_cmd_t cmd_d, cmd_q;
  logic [HOST_W-1:0] rd_q [2];

  always_comb begin
    cmd_hit = host_we && (host_addr == CMD_A);
    abort   = cmd_hit && host_wdata[CMD_ABT];
    start   = cmd_hit && host_wdata[CMD_GO] && !abort && host_gnt && !busy_q;
    done    = busy_q && sw_ack;
    cap     = done && !abort && !cmd_q.wr;
    cmd_d.page = host_wdata[CMD_PGL +: SEL_W];
    cmd_d.regn = host_wdata[CMD_REGL +: SEL_W];
    cmd_d.wr   = host_wdata[CMD_WR];
    if (start)              busy_d = 1'b1;
    else if (abort || done) busy_d = 1'b0;
    else                    busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (start) cmd_q <= cmd_d;
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    localparam int LSB = (w == 0) ? HOST_W : 0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_q[w] <= '0;
      else if (cap) rd_q[w] <= sw_rdata[LSB +: HOST_W];
    end
  end

  assign busy  = busy_q;
  assign cmd   = cmd_q;
  assign rd_hi = rd_q[0];
  assign rd_lo = rd_q[1];

  if (SW_W != 2 * HOST_W) begin : g_bad_width
    initial $error("data width must be twice the host width");
  end
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import srab_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8,
  localparam int SW_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              sw_init_done,
  input  logic              agent_req,
  output logic              agent_gnt,
  output logic              sw_req,
  output logic [SEL_W-1:0]  sw_page,
  output logic [SEL_W-1:0]  sw_reg,
  output logic              sw_write,
  output logic [SW_W-1:0]   sw_wdata,
  input  logic              sw_ack,
  input  logic [SW_W-1:0]   sw_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic              req, ien, host_gnt, busy;
  logic [HOST_W-1:0] wd_hi, wd_lo, rd_hi, rd_lo;
  srab_cmd_t         cmd;

  srab_host_regs #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .req(req), .ien(ien), .wd_hi(wd_hi), .wd_lo(wd_lo)
  );

  srab_arbiter u_arb (
    .clk(clk), .rst_n(rst_n_s), .host_req(req), .busy(busy),
    .agent_req(agent_req), .host_gnt(host_gnt), .agent_gnt(agent_gnt)
  );

  srab_cmd_engine #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_gnt(host_gnt), .sw_ack(sw_ack),
    .sw_rdata(sw_rdata), .busy(busy), .cmd(cmd), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  logic [HOST_W-1:0] cmd_word, ctl_word;

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_PGL +: SEL_W]  = cmd.page;
    cmd_word[CMD_REGL +: SEL_W] = cmd.regn;
    cmd_word[CMD_WR]            = cmd.wr;
    cmd_word[CMD_GO]            = busy;
    ctl_word = '0;
    ctl_word[CTL_IEN]  = ien;
    ctl_word[CTL_REQ]  = req;
    ctl_word[CTL_GNT]  = host_gnt;
    ctl_word[CTL_INIT] = sw_init_done;
    unique case (host_addr)
      ADDR_W'(OFF_CMD): host_rdata = cmd_word;
      ADDR_W'(OFF_WHI): host_rdata = wd_hi;
      ADDR_W'(OFF_WLO): host_rdata = wd_lo;
      ADDR_W'(OFF_RHI): host_rdata = rd_hi;
      ADDR_W'(OFF_RLO): host_rdata = rd_lo;
      ADDR_W'(OFF_CTL): host_rdata = ctl_word;
      default:          host_rdata = '0;
    endcase
  end

  assign sw_req   = busy;
  assign sw_page  = cmd.page;
  assign sw_reg   = cmd.regn;
  assign sw_write = cmd.wr;
  assign sw_wdata = {wd_hi, wd_lo};
endmodule

// File: rtl/sw_reg_bridge_chk.sv
module sw_reg_bridge_chk
  import srab_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] host_addr,
  input logic       host_we,
  input logic [31:0] host_wdata,
  input logic       agent_gnt,
  input logic       host_gnt,
  input logic       sw_req,
  input logic [7:0] sw_page,
  input logic [7:0] sw_reg,
  input logic       sw_write,
  input logic       sw_ack
);
  logic abort_wr;
  assign abort_wr = host_we && (host_addr == OFF_CMD) && host_wdata[CMD_ABT];

  assert_grant_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(agent_gnt && host_gnt));

  assert_agent_off_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(agent_gnt && sw_req));

  assert_start_needs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_req) |-> $past(host_we && host_addr == OFF_CMD && host_wdata[CMD_GO] && host_gnt));

  assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && $past(sw_req)) |-> ($stable(sw_page) && $stable(sw_reg) && $stable(sw_write)));

  assert_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_ack) |=> !sw_req);

  assert_abort_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && abort_wr) |=> !sw_req);
endmodule

bind sw_reg_bridge sw_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
  .host_wdata(host_wdata), .agent_gnt(agent_gnt), .host_gnt(host_gnt),
  .sw_req(sw_req), .sw_page(sw_page), .sw_reg(sw_reg), .sw_write(sw_write),
  .sw_ack(sw_ack)
);

// File: tb/sw_reg_bridge_tb.sv
module sw_reg_bridge_tb;
  localparam logic [7:0] A_CMD = 8'h2C, A_WHI = 8'h30, A_WLO = 8'h34;
  localparam logic [7:0] A_RHI = 8'h38, A_RLO = 8'h3C, A_CTL = 8'h40;
  localparam int NV = 6;
  // {write, page, reg, data}
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 64'h0123_4567_89AB_CDEF},
    {1'b1, 8'h02, 8'h10, 64'hDEAD_BEEF_0000_FFFF},
    {1'b0, 8'hFF, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 8'h34, 8'h5A, 64'h0000_0000_0000_00A5},
    {1'b0, 8'h80, 8'h01, 64'h0000_FFFF_1234_5678},
    {1'b1, 8'hFF, 8'h00, 64'h8000_0000_0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        sw_init_done = 1'b1;
  logic        agent_req = 1'b0;
  logic        agent_gnt;
  logic        sw_req;
  logic [7:0]  sw_page, sw_reg;
  logic        sw_write;
  logic [63:0] sw_wdata;
  logic        sw_ack = 1'b0;
  logic [63:0] sw_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sw_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sw_init_done(sw_init_done),
    .agent_req(agent_req), .agent_gnt(agent_gnt), .sw_req(sw_req),
    .sw_page(sw_page), .sw_reg(sw_reg), .sw_write(sw_write), .sw_wdata(sw_wdata),
    .sw_ack(sw_ack), .sw_rdata(sw_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    host_addr = a; host_we = 1'b1; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic ack(input logic [63:0] d);
    sw_ack = 1'b1; sw_rdata = d;
    @(negedge clk);
    sw_ack = 1'b0; sw_rdata = '0;
  endtask

  initial begin
    cyc(100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] last_rd;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(A_CMD, v); check("R1 cmd", v, 0);
    rd(A_CTL, v); check("R1 ctl", v, 32'h40);
    rd(A_RHI, v); check("R1 rhi", v, 0);
    rd(A_RLO, v); check("R1 rlo", v, 0);
    rd(A_WHI, v); check("R1 whi", v, 0);
    check("R1 sw_req", sw_req, 0);
    check("R1 agent_gnt", agent_gnt, 0);

    // R9 command without grant
    wr(A_CMD, 32'h1122_0003);
    cyc(1);
    rd(A_CMD, v); check("R9 cmd ignored", v, 0);
    check("R9 no sw_req", sw_req, 0);

    // R2 / R3 request and grant
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, v); check("R2 rw bits, grant not yet", v, 32'h4A);
    cyc(1);
    rd(A_CTL, v); check("R3 grant set", v, 32'h5A);
    sw_init_done = 1'b0;
    rd(A_CTL, v); check("R2 init-done read-only", v, 32'h1A);
    sw_init_done = 1'b1;
    wr(A_CTL, 32'h0000_0008);
    rd(A_CTL, v); check("R2 ien cleared", v, 32'h58);

    // table of accesses (R5 R6 R7 R8)
    last_rd = '0;
    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [7:0]  pg, rg;
      logic [63:0] dat;
      {w, pg, rg, dat} = VEC[i];
      if (w) begin
        wr(A_WHI, dat[63:32]);
        wr(A_WLO, dat[31:0]);
      end
      wr(A_CMD, {pg, rg, 14'b0, w, 1'b1});
      check("R5 sw_req", sw_req, 1);
      check("R5 page/reg/dir", {sw_page, sw_reg, sw_write}, {pg, rg, w});
      if (w) check("R7 sw_wdata", sw_wdata, dat);
      rd(A_CMD, v); check("R6 go pending", v, {pg, rg, 14'b0, w, 1'b1});
      cyc(2);
      check("R6 still pending", sw_req, 1);
      ack(w ? 64'hBAD0_BAD0_BAD0_BAD0 : dat);
      check("R6 sw_req cleared", sw_req, 0);
      rd(A_CMD, v); check("R6 go cleared", v[0], 0);
      if (!w) last_rd = dat;
      rd(A_RHI, v); check("R8 read high", v, last_rd[63:32]);
      rd(A_RLO, v); check("R8 read low", v, last_rd[31:0]);
    end

    // R11 command while busy, then R10 abort
    wr(A_CMD, 32'h0506_0001);
    wr(A_CMD, 32'h0708_0003);
    check("R11 page kept", {sw_page, sw_reg, sw_write}, {8'h05, 8'h06, 1'b0});
    rd(A_CMD, v); check("R11 cmd kept", v, 32'h0506_0001);
    wr(A_CMD, 32'h0000_0004);
    check("R10 sw_req dropped", sw_req, 0);
    rd(A_CMD, v); check("R10 go cleared", v[0], 0);
    ack(64'hAAAA_5555_AAAA_5555);
    rd(A_RHI, v); check("R10 rhi kept", v, last_rd[63:32]);
    rd(A_RLO, v); check("R10 rlo kept", v, last_rd[31:0]);

    // R3 release
    wr(A_CTL, 32'h0);
    cyc(1);
    rd(A_CTL, v); check("R3 grant released", v, 32'h40);

    // R4 agent arbitration
    agent_req = 1'b1;
    cyc(1);
    check("R4 agent granted", agent_gnt, 1);
    wr(A_CTL, 32'h8);
    cyc(3);
    rd(A_CTL, v); check("R4 host withheld", v[4], 0);
    wr(A_CMD, 32'h0101_0001);
    check("R9 no access under agent", sw_req, 0);
    agent_req = 1'b0;
    cyc(1);
    check("R4 agent released", agent_gnt, 0);
    cyc(1);
    rd(A_CTL, v); check("R4 host granted after agent", v[4], 1);
    agent_req = 1'b1;
    cyc(3);
    check("R4 agent blocked", agent_gnt, 0);
    agent_req = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule